// File: doc/BRIEF.md
# Seven-Pin GPIO Port with Edge Interrupts

This block controls seven general-purpose pins from a byte-wide register bus. Software sets each pin's direction and output level. When a pin is an input, its output bit turns the weak pull-up on or off instead. Software reads the synchronized pin levels and gets a per-pin interrupt flag when a chosen edge occurs. Each pin can choose rising or falling edge detection. The flags are masked by an enable register and combined into one interrupt line.

A control bit hands the four lowest pins to a debug access port, and this bit is set after reset. While the bit is set, those pins are neither driven nor pulled up by this block, whatever the GPIO or alternate-function settings are. Each pin also has an alternate-function override input. When it is asserted, a neighbouring function supplies the pin's output enable and output data. Edge detection keeps working in every ownership mode.

A small sequencer handles the cycles after reset, while the input synchronizer is still filling. It moves through the states `S_FILL0` → `S_FILL1` → `S_FILL2` → `S_ARMED`, one state per clock, and stays in `S_ARMED`. Edge detection is allowed only in `S_ARMED`. This stops the reset values of the synchronizer from raising false flags.

Top module: `gpio7_port`

## Requirements
- R1: After reset the registers read as follows: direction 0x00, output 0xFF, edge-select 0x00, flag 0x00, enable 0x00, control 0x01. Address 7 reads 0x00 and `irq` is 0.
- R2: The bus addresses are: direction 0, output 1, input 2 (read-only), edge-select 3, flag 4, enable 5, control 6 (bit 0 is the debug-port enable). Writes take effect at the clock edge on which `bus_wr` is high. Bit 7 ignores writes and always reads its reset value: 0, except for output and input, which read 1.
- R3: For a pin that is neither debug-owned nor overridden, direction bit 1 gives pad_oe=1, pad_do equal to the output bit, and pad_pu=0.
- R4: For a pin that is neither debug-owned nor overridden, direction bit 0 gives pad_oe=0, and pad_pu equals the output bit.
- R5: The input register shows `pad_di` through a two-flop synchronizer. A change made between clock edges is readable after the second following rising edge, in every pin mode. Bit 7 reads 1.
- R6: While control bit 0 is 1, pins 0 to 3 have pad_oe=0, pad_do=0 and pad_pu=0 regardless of any other setting. Pins 4 to 6 are not affected.
- R7: When `alt_en[i]` is 1 and pin i is not debug-owned, pad_oe[i] equals alt_oe[i], pad_do[i] equals alt_do[i], and pad_pu[i] is 0.
- R8: Edge-select bit 0 sets the flag on a rising edge of the synchronized pin, and bit 1 sets it on a falling edge. The flag is visible at the third rising clock edge after the pin changes. Detection works whatever the pin's ownership or mode.
- R9: Writing 0 to a flag bit clears it and writing 1 leaves it unchanged. If a set event and a clear arrive in the same cycle, the flag ends up set.
- R10: `irq` is 1 exactly when some flag bit and the matching enable bit are both 1.
- R11: Changing an edge-select bit while the pin level is steady does not set a flag.
- R12: No flag is set during the three sequencer states that follow reset, even when the pins are high from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| pad_di | input | 7 | Pin levels from the pads |
| alt_en | input | 7 | Per-pin alternate-function override |
| alt_oe | input | 7 | Alternate-function output enable |
| alt_do | input | 7 | Alternate-function output data |
| pad_oe | output | 7 | Pad output enable |
| pad_do | output | 7 | Pad output data |
| pad_pu | output | 7 | Pad weak pull-up enable |
| irq | output | 1 | Combined masked interrupt |

## Verification
The pad multiplexer is swept over 32 combinations of direction, output, override enable, override enable-out and override data. Each pin gets a different combination, and the sweep runs with the debug-port bit both set and cleared. This shows the GPIO, pull-up, override and debug-owned outcomes apart pin by pin. The edge detector is driven with a rise and then a fall on every pin under both edge selections. These runs change the override and debug-ownership settings, so they show that the selected polarity alone decides whether a flag is set. Three further patterns cover corner cases: pins that are high while reset is released, edge-select toggles on pins held steady, and a clear that lands in the same cycle as a set. They separate real edges from the effects of reset, of reconfiguration and of write collisions.

// File: rtl/gpio7_pkg.sv
package gpio7_pkg;
    localparam int unsigned BUS_W  = 8;
    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_DIR  = 3'd0,
        A_OUT  = 3'd1,
        A_IN   = 3'd2,
        A_ESEL = 3'd3,
        A_FLAG = 3'd4,
        A_EN   = 3'd5,
        A_CTRL = 3'd6
    } reg_addr_e;

    typedef enum logic [1:0] {
        S_FILL0,
        S_FILL1,
        S_FILL2,
        S_ARMED
    } warm_state_e;
endpackage

// File: rtl/gpio7_sync.sv
module gpio7_sync #(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;
    logic [W-1:0] stage3_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
            stage3_q <= '0;
        end else begin
            stage1_q <= din;
            stage2_q <= stage1_q;
            stage3_q <= stage2_q;
        end
    end

    assign cur  = stage2_q;
    assign prev = stage3_q;
endmodule

// File: rtl/gpio7_irq.sv
module gpio7_irq
    import gpio7_pkg::*;
#(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] esel,
    input  logic [W-1:0] enable,
    input  logic         clr_wr,
    input  logic [W-1:0] clr_data,
    output logic [W-1:0] flag,
    output logic         irq
);
    warm_state_e  state_q;
    warm_state_e  state_d;
    logic         det_en;
    logic [W-1:0] rise;
    logic [W-1:0] fall;
    logic [W-1:0] hit;
    logic [W-1:0] keep;
    logic [W-1:0] flag_q;
    logic [W-1:0] flag_d;

    // Sequencer state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_FILL0;
        else        state_q <= state_d;
    end

    // Sequencer next state and output
    always_comb begin
        state_d = state_q;
        det_en  = 1'b0;
        unique case (state_q)
            S_FILL0: state_d = S_FILL1;
            S_FILL1: state_d = S_FILL2;
            S_FILL2: state_d = S_ARMED;
            S_ARMED: det_en  = 1'b1;
        endcase
    end

    always_comb begin
        rise   = cur & ~prev;
        fall   = ~cur & prev;
        hit    = det_en ? ((rise & ~esel) | (fall & esel)) : '0;
        keep   = clr_wr ? clr_data : '1;
        flag_d = (flag_q & keep) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;
    assign irq  = |(flag_q & enable);

    // R12: nothing flagged until the synchronizer has filled
    a_r12_quiet_warmup: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_ARMED) |-> (flag_q == '0));

    // R11: a flag bit can only rise on a pin whose sample changed
    a_r11_flag_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(cur ^ prev)) == '0));

    // R9: a written zero clears the bit unless an edge arrived that cycle
    a_r9_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((flag_q & ~$past(clr_data) & ~$past(hit)) == '0));
endmodule

// File: rtl/gpio7_padmux.sv
module gpio7_padmux #(
    parameter int unsigned W        = 7,
    parameter int unsigned TAP_PINS = 4
) (
    input  logic         tap_en,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] dout,
    input  logic [W-1:0] alt_en,
    input  logic [W-1:0] alt_oe,
    input  logic [W-1:0] alt_do,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_do,
    output logic [W-1:0] pad_pu
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        localparam logic OWNABLE = (i < TAP_PINS);
        logic owned;
        assign owned     = tap_en & OWNABLE;
        assign pad_oe[i] = owned ? 1'b0 : (alt_en[i] ? alt_oe[i] : dir[i]);
        assign pad_do[i] = owned ? 1'b0 : (alt_en[i] ? alt_do[i] : dout[i]);
        assign pad_pu[i] = owned ? 1'b0 : (alt_en[i] ? 1'b0 : (~dir[i] & dout[i]));
    end
endmodule

// File: rtl/gpio7_port.sv
module gpio7_port
    import gpio7_pkg::*;
#(
    parameter int unsigned NPINS    = 7,
    parameter int unsigned TAP_PINS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_di,
    input  logic [NPINS-1:0]  alt_en,
    input  logic [NPINS-1:0]  alt_oe,
    input  logic [NPINS-1:0]  alt_do,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_do,
    output logic [NPINS-1:0]  pad_pu,
    output logic              irq
);
    localparam int unsigned RSV_W = BUS_W - NPINS;

    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] out_q;
    logic [NPINS-1:0] esel_q;
    logic [NPINS-1:0] en_q;
    logic             tap_q;
    logic [NPINS-1:0] in_cur;
    logic [NPINS-1:0] in_prev;
    logic [NPINS-1:0] flag;
    logic             flag_wr;
    logic             unused_rsv_wr;

    assign unused_rsv_wr = ^bus_wdata[BUS_W-1:NPINS];
    assign flag_wr       = bus_wr && (bus_addr == A_FLAG);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '0;
            out_q  <= '1;
            esel_q <= '0;
            en_q   <= '0;
            tap_q  <= 1'b1;
        end else if (bus_wr) begin
            case (bus_addr)
                A_DIR:   dir_q  <= bus_wdata[NPINS-1:0];
                A_OUT:   out_q  <= bus_wdata[NPINS-1:0];
                A_ESEL:  esel_q <= bus_wdata[NPINS-1:0];
                A_EN:    en_q   <= bus_wdata[NPINS-1:0];
                A_CTRL:  tap_q  <= bus_wdata[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (bus_addr)
            A_DIR:   bus_rdata = {{RSV_W{1'b0}}, dir_q};
            A_OUT:   bus_rdata = {{RSV_W{1'b1}}, out_q};
            A_IN:    bus_rdata = {{RSV_W{1'b1}}, in_cur};
            A_ESEL:  bus_rdata = {{RSV_W{1'b0}}, esel_q};
            A_FLAG:  bus_rdata = {{RSV_W{1'b0}}, flag};
            A_EN:    bus_rdata = {{RSV_W{1'b0}}, en_q};
            A_CTRL:  bus_rdata = {{(BUS_W-1){1'b0}}, tap_q};
            default: bus_rdata = '0;
        endcase
    end

    gpio7_sync #(.W(NPINS)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pad_di),
        .cur  (in_cur),
        .prev (in_prev)
    );

    gpio7_irq #(.W(NPINS)) irq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cur     (in_cur),
        .prev    (in_prev),
        .esel    (esel_q),
        .enable  (en_q),
        .clr_wr  (flag_wr),
        .clr_data(bus_wdata[NPINS-1:0]),
        .flag    (flag),
        .irq     (irq)
    );

    gpio7_padmux #(.W(NPINS), .TAP_PINS(TAP_PINS)) padmux_i (
        .tap_en(tap_q),
        .dir   (dir_q),
        .dout  (out_q),
        .alt_en(alt_en),
        .alt_oe(alt_oe),
        .alt_do(alt_do),
        .pad_oe(pad_oe),
        .pad_do(pad_do),
        .pad_pu(pad_pu)
    );

    // R6: debug-owned pins are left undriven and unpulled
    a_r6_tap_owns_low: assert property (@(posedge clk) disable iff (!rst_n)
        tap_q |-> ((pad_oe[TAP_PINS-1:0] == '0) && (pad_pu[TAP_PINS-1:0] == '0)
                   && (pad_do[TAP_PINS-1:0] == '0)));

    // R10: the interrupt line needs a flagged, enabled pin
    a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq);
endmodule

// File: tb/gpio7_port_tb_top.sv
`timescale 1ns/1ps
module gpio7_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [6:0] pad_di = 7'h7F;
    logic [6:0] alt_en = 7'h00;
    logic [6:0] alt_oe = 7'h00;
    logic [6:0] alt_do = 7'h00;
    logic [6:0] pad_oe;
    logic [6:0] pad_do;
    logic [6:0] pad_pu;
    logic       irq;

    int n_checks = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    gpio7_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_di(pad_di),
        .alt_en(alt_en), .alt_oe(alt_oe), .alt_do(alt_do),
        .pad_oe(pad_oe), .pad_do(pad_do), .pad_pu(pad_pu), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [4:0] combo(input int c, input int i);
        return 5'((c + i * 5) & 31);
    endfunction

    initial begin
        #1_000_000;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [6:0] dirv, outv, eo, ed, ep;
        cyc(2);
        rst_n = 1'b1;
        // R1 reset state
        rd(3'd0, d); check("R1 dir", d, 8'h00);
        rd(3'd1, d); check("R1 out", d, 8'hFF);
        rd(3'd3, d); check("R1 esel", d, 8'h00);
        rd(3'd4, d); check("R1 flag", d, 8'h00);
        rd(3'd5, d); check("R1 en", d, 8'h00);
        rd(3'd6, d); check("R1 ctrl", d, 8'h01);
        rd(3'd7, d); check("R1 addr7", d, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 R6 pu", {1'b0, pad_pu}, 8'h70);
        check("R1 R6 oe", {1'b0, pad_oe}, 8'h00);
        // R12 pins high from reset: no flag during warm-up
        cyc(6);
        rd(3'd4, d); check("R12 warmup flag", d, 8'h00);
        rd(3'd2, d); check("R5 input high", d, 8'hFF);
        pad_di = 7'h00;
        cyc(5);
        rd(3'd4, d); check("R8 fall with rise select", d, 8'h00);
        // R5 latency
        @(negedge clk); pad_di = 7'h55;
        @(negedge clk); rd(3'd2, d); check("R5 one edge", d, 8'h80);
        @(negedge clk); rd(3'd2, d); check("R5 two edges", d, 8'hD5);
        wr(3'd4, 8'h00);
        pad_di = 7'h00; cyc(4); wr(3'd4, 8'h00);
        // R2 reserved bit and addressing
        wr(3'd0, 8'hFF); rd(3'd0, d); check("R2 dir bit7", d, 8'h7F);
        wr(3'd1, 8'h00); rd(3'd1, d); check("R2 out bit7", d, 8'h80);
        wr(3'd5, 8'hA5); rd(3'd5, d); check("R2 en write", d, 8'h25);
        wr(3'd3, 8'h81); rd(3'd3, d); check("R2 esel write", d, 8'h01);
        wr(3'd7, 8'hFF); rd(3'd0, d); check("R2 addr7 no effect", d, 8'h7F);
        wr(3'd6, 8'hFE); rd(3'd6, d); check("R2 ctrl clear", d, 8'h00);
        wr(3'd5, 8'h00); wr(3'd3, 8'h00);
        // Pad mux sweep: R3 R4 R6 R7
        for (int t = 0; t < 2; t++) begin
            wr(3'd6, 8'(t));
            for (int c = 0; c < 32; c++) begin
                logic [6:0] xoe, xdo, xpu;
                for (int i = 0; i < 7; i++) begin
                    logic [4:0] v;
                    v = combo(c, i);
                    dirv[i] = v[0]; outv[i] = v[1]; ep[i] = v[2];
                    eo[i] = v[3]; ed[i] = v[4];
                    if (t == 1 && i < 4) begin
                        xoe[i] = 1'b0; xdo[i] = 1'b0; xpu[i] = 1'b0;
                    end else if (v[2]) begin
                        xoe[i] = v[3]; xdo[i] = v[4]; xpu[i] = 1'b0;
                    end else begin
                        xoe[i] = v[0]; xdo[i] = v[1]; xpu[i] = ~v[0] & v[1];
                    end
                end
                wr(3'd0, {1'b0, dirv});
                wr(3'd1, {1'b0, outv});
                alt_en = ep; alt_oe = eo; alt_do = ed;
                #1;
                check("R3 R6 R7 pad_oe", {1'b0, pad_oe}, {1'b0, xoe});
                check("R3 R6 R7 pad_do", {1'b0, pad_do}, {1'b0, xdo});
                check("R4 R6 R7 pad_pu", {1'b0, pad_pu}, {1'b0, xpu});
            end
        end
        // Edge sweep: R8 R10
        for (int s = 0; s < 2; s++) begin
            wr(3'd6, 8'(s));
            wr(3'd3, (s == 1) ? 8'h7F : 8'h00);
            for (int i = 0; i < 7; i++) begin
                logic [7:0] bit_i;
                bit_i = 8'(1 << i);
                alt_en = (i % 2 == 1) ? 7'h7F : 7'h00;
                wr(3'd5, bit_i);
                wr(3'd4, 8'h00);
                cyc(1); pad_di[i] = 1'b1; cyc(4);
                rd(3'd4, d); check("R8 rise", d, (s == 0) ? bit_i : 8'h00);
                check("R10 irq rise", {7'd0, irq}, (s == 0) ? 8'h01 : 8'h00);
                wr(3'd4, 8'h00);
                pad_di[i] = 1'b0; cyc(4);
                rd(3'd4, d); check("R8 fall", d, (s == 1) ? bit_i : 8'h00);
                check("R10 irq fall", {7'd0, irq}, (s == 1) ? 8'h01 : 8'h00);
                wr(3'd4, 8'h00);
            end
        end
        alt_en = 7'h00;
        wr(3'd3, 8'h00); wr(3'd5, 8'h00); wr(3'd4, 8'h00);
        // R9 set and clear in the same cycle
        @(negedge clk); pad_di[2] = 1'b1;
        @(negedge clk);
        @(negedge clk); bus_addr = 3'd4; bus_wdata = 8'h00; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        rd(3'd4, d); check("R9 set wins", d, 8'h04);
        wr(3'd4, 8'h7F); rd(3'd4, d); check("R9 write one keeps", d, 8'h04);
        // R10 masking
        check("R10 no enable", {7'd0, irq}, 8'h00);
        wr(3'd5, 8'h7B); check("R10 other enables", {7'd0, irq}, 8'h00);
        wr(3'd5, 8'h04); check("R10 matching enable", {7'd0, irq}, 8'h01);
        wr(3'd4, 8'hFB); rd(3'd4, d); check("R9 write zero clears", d, 8'h00);
        check("R10 cleared", {7'd0, irq}, 8'h00);
        // R11 edge-select toggle on steady pins (pin 2 high, others low)
        wr(3'd3, 8'h7F); cyc(3); wr(3'd3, 8'h00); cyc(3);
        wr(3'd3, 8'h04); cyc(3);
        rd(3'd4, d); check("R11 select toggle", d, 8'h00);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule